// File: doc/BRIEF.md
# Dual-Channel Disk Register Access Decoder

This block sits between a host I/O port and the register files of a two-channel disk controller. Each host access is compared against five programmable address windows: command and control blocks for the first channel, the same pair for the second channel, and one shared DMA-engine window. A matching access is turned into a one-hot block strobe with a window-relative offset. The drive-side logic sees that strobe with the selected drive and the write data, and it returns read data in the same cycle.

The decoder keeps a per-channel shadow of which drive (drive 0 or drive 1) is selected. It updates the shadow by snooping command-block writes. Accesses to a selected drive that is not fitted are completed locally. A 32-bit access to the data port is broken into two 16-bit drive beats. Two enables from the host's PCI command register gate the block: one enables all I/O, and one enables writes into the DMA window.

Requests use a valid/ready handshake. The first drive beat appears in the cycle after acceptance. The response, a one-cycle pulse with an error flag and read data, arrives in the cycle after the last beat.

Top module: `ide_io_decode`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and drv_valid are 0, every window base is 0, and both channels select drive 0.
- R2: A base load (cfg_load with window index cfg_win: 0 first-channel command, 1 first-channel control, 2 second-channel command, 3 second-channel control, 4 DMA) stores a nonzero cfg_base. A base value of zero leaves the old base in place.
- R3: A request whose req_size is not 1, 2 or 4 gets rsp_err=1 and rsp_rdata=0, and it produces no drive beat. This holds whether io_en is set or not.
- R4: With io_en low, a request of legal size gets rsp_err=0 and rsp_rdata=0. It produces no drive beat and leaves the drive selection unchanged.
- R5: A window covers base <= addr < base+size, with sizes CMD_SIZE, CTL_SIZE and BM_SIZE. Windows are tried in index order 0..4 and the lowest index wins. drv_offset is addr minus that base, and drv_strobe bit i marks window i for i=0..3.
- R6: With io_en high, an address inside no window gets rsp_err=1 and rsp_rdata=0, with no drive beat.
- R7: In the DMA window, offsets below BM_SIZE/2 raise drv_strobe bit 4 with the offset unchanged. Higher offsets raise bit 5 with BM_SIZE/2 subtracted.
- R8: With bm_en low, writes to the DMA window complete with rsp_err=0 and no drive beat. Reads are still forwarded.
- R9: A byte write to command-block offset 6 sets that channel's selection to req_wdata bit 4 (1 = drive 1). The write itself goes to the newly selected drive, which drv_dev reports.
- R10: drv_present bit 2*channel+drive flags a fitted drive (channel 0 = first). A command or control access to an unfitted selected drive gets rsp_err=0 with no drive beat. Its read data is 0.
- R11: A 4-byte access to command offset 0 gives two consecutive drive beats, each with size 2 and offset 0. The low half goes first, on drv_wdata[15:0]. The read response is {second beat rdata[15:0], first beat rdata[15:0]}.
- R12: Command offset 0 accepts sizes 2 and 4 only, and the other command offsets accept size 1 only. A violation gets rsp_err=1 with no drive beat and no selection change.
- R13: The first drive beat is in the cycle after acceptance, and the response is one cycle after the last beat. req_ready is low from acceptance until the response cycle, and read data is zero on every write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O space enable |
| bm_en | input | 1 | DMA-engine enable (gates writes to the DMA window) |
| drv_present | input | 4 | Fitted drives, bit 2*channel+drive |
| cfg_load | input | 1 | Load a window base |
| cfg_win | input | 3 | Window index for the base load |
| cfg_base | input | AW | Base value, zero ignored |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Decoder can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | DW | Write data |
| drv_valid | output | 1 | Drive-side beat valid |
| drv_strobe | output | 6 | One-hot target block |
| drv_offset | output | OW | Offset within the target block |
| drv_write | output | 1 | Beat is a write |
| drv_size | output | 3 | Beat size in bytes |
| drv_dev | output | 1 | Selected drive of the channel |
| drv_wdata | output | DW | Beat write data |
| drv_rdata | input | DW | Beat read data, valid during the beat |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Access error |
| rsp_rdata | output | DW | Response read data |

## Verification
Two functions can fall in one cycle: the drive-select shadow update and the forwarding of the write that causes it. The bench writes offset 6 so that the selection flips onto an unfitted drive and then back onto a fitted one. A drive beat must appear only when the newly selected drive is fitted, and drv_dev must already show the new value in that same beat. A second overlap comes from programming two windows over one address, so that the priority pick and the offset subtraction act on the same access. The behavioural model in the bench predicts strobe, offset, drive and response data for every cycle of each access, and the bench compares the outputs against it.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int NUM_WIN = 5;
  localparam int NUM_STB = 6;

  typedef enum logic [2:0] {
    WIN_C0_CMD = 3'd0,
    WIN_C0_CTL = 3'd1,
    WIN_C1_CMD = 3'd2,
    WIN_C1_CTL = 3'd3,
    WIN_DMA    = 3'd4
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2
  } dec_state_e;

endpackage

// File: rtl/ide_win_slot.sv
module ide_win_slot #(
  parameter int AW   = 16,
  parameter int SIZE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] rel
);
  localparam logic [AW:0] SPAN = (AW+1)'(SIZE);

  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (load && (base_in != '0)) begin
      base_q <= base_in;
    end
  end

  always_comb begin
    rel = addr - base_q;
    hit = (addr >= base_q) && ({1'b0, rel} < SPAN);
  end
endmodule

// File: rtl/ide_dev_select.sv
module ide_dev_select #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] upd,
  input  logic           val,
  output logic [NCH-1:0] sel
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        sel[c] <= 1'b0;
      end else if (upd[c]) begin
        sel[c] <= val;
      end
    end
  end
endmodule

// File: rtl/ide_req_classify.sv
module ide_req_classify
  import ide_dec_pkg::*;
#(
  parameter int AW       = 16,
  parameter int OW       = 4,
  parameter int BM_SPAN  = 8,
  parameter int SEL_OFS  = 6,
  parameter int DATA_OFS = 0
) (
  input  logic [NUM_WIN-1:0]         hit,
  input  logic [NUM_WIN-1:0][AW-1:0] rel,
  input  logic                       write,
  input  logic [2:0]                 size,
  input  logic                       sel_bit,
  input  logic                       io_en,
  input  logic                       bm_en,
  input  logic [1:0]                 sel,
  input  logic [3:0]                 present,
  output logic                       err,
  output logic                       fwd,
  output logic                       split,
  output logic [NUM_STB-1:0]         strobe,
  output logic [OW-1:0]              offset,
  output logic                       dev,
  output logic [1:0]                 sel_upd
);
  localparam logic [OW-1:0] SPAN_O = OW'(BM_SPAN);
  localparam logic [OW-1:0] SEL_O  = OW'(SEL_OFS);
  localparam logic [OW-1:0] DATA_O = OW'(DATA_OFS);

  win_e          win;
  logic          any_hit, size_ok, is_cmd, is_dma, ch, cmd_size_ok;
  logic          live, sel_wr, dma_hi;
  logic [OW-1:0] ofs;

  always_comb begin
    win     = WIN_C0_CMD;
    any_hit = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win     = win_e'(i[2:0]);
        any_hit = 1'b1;
      end
    end
    ofs     = rel[win][OW-1:0];
    size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    is_cmd  = (win == WIN_C0_CMD) || (win == WIN_C1_CMD);
    is_dma  = (win == WIN_DMA);
    ch      = (win == WIN_C1_CMD) || (win == WIN_C1_CTL);
    cmd_size_ok = (ofs == DATA_O) ? ((size == 3'd2) || (size == 3'd4))
                                  : (size == 3'd1);
    err    = !size_ok || (io_en && (!any_hit || (is_cmd && !cmd_size_ok)));
    live   = !err && io_en;
    sel_wr = live && is_cmd && write && (ofs == SEL_O);
    dev    = sel_wr ? sel_bit : sel[ch];
    dma_hi = ofs >= SPAN_O;

    sel_upd = 2'b00;
    if (sel_wr) sel_upd[ch] = 1'b1;

    if (is_dma) begin
      fwd    = live && (!write || bm_en);
      offset = dma_hi ? (ofs - SPAN_O) : ofs;
    end else begin
      fwd    = live && present[{ch, dev}];
      offset = ofs;
    end
    split = fwd && is_cmd && (ofs == DATA_O) && (size == 3'd4);

    strobe = '0;
    if (fwd) begin
      if (is_dma) strobe[dma_hi ? 5 : 4] = 1'b1;
      else        strobe[win]            = 1'b1;
    end
  end
endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_dec_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int CMD_SIZE = 8,
  parameter int CTL_SIZE = 4,
  parameter int BM_SIZE  = 16,
  parameter int SEL_OFS  = 6,
  parameter int SEL_BIT  = 4,
  parameter int DATA_OFS = 0,
  localparam int MAXSZ   = (BM_SIZE > CMD_SIZE)
                           ? ((BM_SIZE > CTL_SIZE) ? BM_SIZE : CTL_SIZE)
                           : ((CMD_SIZE > CTL_SIZE) ? CMD_SIZE : CTL_SIZE),
  localparam int OW      = $clog2(MAXSZ)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_en,
  input  logic          bm_en,
  input  logic [3:0]    drv_present,
  input  logic          cfg_load,
  input  logic [2:0]    cfg_win,
  input  logic [AW-1:0] cfg_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          drv_valid,
  output logic [5:0]    drv_strobe,
  output logic [OW-1:0] drv_offset,
  output logic          drv_write,
  output logic [2:0]    drv_size,
  output logic          drv_dev,
  output logic [DW-1:0] drv_wdata,
  input  logic [DW-1:0] drv_rdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  localparam int HW      = DW / 2;
  localparam int BM_SPAN = BM_SIZE / 2;

  dec_state_e                 st;
  logic [NUM_WIN-1:0]         hit;
  logic [NUM_WIN-1:0][AW-1:0] rel;
  logic [1:0]                 sel, sel_upd;
  logic                       accept;
  logic                       c_err, c_fwd, c_split, c_dev;
  logic [NUM_STB-1:0]         c_strobe;
  logic [OW-1:0]              c_offset;
  logic                       p_err, p_split, p_fwd, p_write;
  logic [HW-1:0]              hi_wdata, lo_rdata;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam int SZ = (i == 4) ? BM_SIZE : ((i % 2) == 0 ? CMD_SIZE : CTL_SIZE);
    ide_win_slot #(.AW(AW), .SIZE(SZ)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .load    (cfg_load && (cfg_win == 3'(i))),
      .base_in (cfg_base),
      .addr    (req_addr),
      .hit     (hit[i]),
      .rel     (rel[i])
    );
  end

  ide_dev_select #(.NCH(2)) u_sel (
    .clk (clk),
    .rst (rst),
    .upd (sel_upd & {2{accept}}),
    .val (req_wdata[SEL_BIT]),
    .sel (sel)
  );

  ide_req_classify #(
    .AW(AW), .OW(OW), .BM_SPAN(BM_SPAN), .SEL_OFS(SEL_OFS), .DATA_OFS(DATA_OFS)
  ) u_cls (
    .hit     (hit),
    .rel     (rel),
    .write   (req_write),
    .size    (req_size),
    .sel_bit (req_wdata[SEL_BIT]),
    .io_en   (io_en),
    .bm_en   (bm_en),
    .sel     (sel),
    .present (drv_present),
    .err     (c_err),
    .fwd     (c_fwd),
    .split   (c_split),
    .strobe  (c_strobe),
    .offset  (c_offset),
    .dev     (c_dev),
    .sel_upd (sel_upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      drv_valid  <= 1'b0;
      drv_strobe <= '0;
      drv_offset <= '0;
      drv_write  <= 1'b0;
      drv_size   <= '0;
      drv_dev    <= 1'b0;
      drv_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      p_err      <= 1'b0;
      p_split    <= 1'b0;
      p_fwd      <= 1'b0;
      p_write    <= 1'b0;
      hi_wdata   <= '0;
      lo_rdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st         <= ST_BEAT0;
            drv_valid  <= c_fwd;
            drv_strobe <= c_strobe;
            drv_offset <= c_offset;
            drv_write  <= req_write;
            drv_size   <= c_split ? 3'd2 : req_size;
            drv_dev    <= c_dev;
            drv_wdata  <= c_split ? {{(DW-HW){1'b0}}, req_wdata[HW-1:0]} : req_wdata;
            hi_wdata   <= req_wdata[DW-1:HW];
            p_err      <= c_err;
            p_split    <= c_split;
            p_fwd      <= c_fwd;
            p_write    <= req_write;
          end
        end
        ST_BEAT0: begin
          if (p_split) begin
            st        <= ST_BEAT1;
            drv_wdata <= {{(DW-HW){1'b0}}, hi_wdata};
            lo_rdata  <= drv_rdata[HW-1:0];
          end else begin
            st         <= ST_IDLE;
            drv_valid  <= 1'b0;
            drv_strobe <= '0;
            rsp_valid  <= 1'b1;
            rsp_err    <= p_err;
            rsp_rdata  <= (p_fwd && !p_write) ? drv_rdata : '0;
          end
        end
        ST_BEAT1: begin
          st         <= ST_IDLE;
          drv_valid  <= 1'b0;
          drv_strobe <= '0;
          rsp_valid  <= 1'b1;
          rsp_err    <= 1'b0;
          rsp_rdata  <= p_write ? '0 : {drv_rdata[HW-1:0], lo_rdata};
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_io_decode_chk.sv
module ide_io_decode_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          io_en,
  input logic          bm_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          drv_valid,
  input logic          drv_write,
  input logic [5:0]    drv_strobe,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [DW-1:0] rsp_rdata
);
  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    drv_valid |-> $countones(drv_strobe) == 1);

  // R13
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    drv_valid |-> !req_ready);

  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  io_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && $past(req_valid && req_ready)) |-> $past(io_en));

  // R8
  dma_write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_valid && drv_write && (drv_strobe[4] || drv_strobe[5])) |-> $past(bm_en));

  // R6
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0) && !$past(drv_valid));
endmodule

bind ide_io_decode ide_io_decode_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_en      (io_en),
  .bm_en      (bm_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .drv_valid  (drv_valid),
  .drv_write  (drv_write),
  .drv_strobe (drv_strobe),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/tb_ide_io_decode.sv
module tb_ide_io_decode;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_en = 1'b0, bm_en = 1'b0;
  logic [3:0] drv_present = 4'b0101;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_win = '0;
  logic [AW-1:0] cfg_base = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, drv_valid, drv_write, drv_dev, rsp_valid, rsp_err;
  logic [5:0] drv_strobe;
  logic [3:0] drv_offset;
  logic [2:0] drv_size;
  logic [DW-1:0] drv_wdata, drv_rdata, rsp_rdata;
  logic [15:0] beat_cnt;

  int checks = 0, errors = 0;
  bit done = 0;
  int mb[5];
  int msz[5] = '{8, 4, 8, 4, 16};
  bit msel[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (drv_valid) beat_cnt <= beat_cnt + 16'd1;
  end
  assign drv_rdata = {12'hD00, drv_offset, beat_cnt[9:0], drv_strobe};

  ide_io_decode dut (
    .clk(clk), .rst(rst), .io_en(io_en), .bm_en(bm_en), .drv_present(drv_present),
    .cfg_load(cfg_load), .cfg_win(cfg_win), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .drv_valid(drv_valid), .drv_strobe(drv_strobe), .drv_offset(drv_offset),
    .drv_write(drv_write), .drv_size(drv_size), .drv_dev(drv_dev),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic set_base(input int w, input int val);
    @(negedge clk);
    cfg_load = 1'b1; cfg_win = 3'(w); cfg_base = AW'(val);
    @(negedge clk);
    cfg_load = 1'b0;
    if (val != 0) mb[w] = val;
  endtask

  task automatic access(input bit w, input int addr, input int size,
                        input logic [31:0] wd, input string tag);
    int win = -1, o = 0, sidx = 0, offs = 0, ch = 0;
    bit err = 0, fwd = 0, split = 0, d = 0, upd = 0;
    logic [15:0] lo, hi;
    logic [31:0] exp_rd;
    for (int i = 0; i < 5; i++)
      if (win < 0 && addr >= mb[i] && addr < mb[i] + msz[i]) win = i;
    if (!(size == 1 || size == 2 || size == 4)) err = 1;
    else if (!io_en) err = 0;
    else if (win < 0) err = 1;
    else if (win == 0 || win == 2) begin
      o = addr - mb[win];
      if (o == 0) err = !(size == 2 || size == 4);
      else err = (size != 1);
    end
    if (!err && io_en) begin
      o = addr - mb[win];
      if (win == 4) begin
        sidx = (o >= 8) ? 5 : 4;
        offs = (o >= 8) ? o - 8 : o;
        fwd = !w || bm_en;
      end else begin
        ch = (win >= 2) ? 1 : 0;
        upd = w && (win == 0 || win == 2) && o == 6;
        d = upd ? wd[4] : msel[ch];
        fwd = drv_present[2*ch + int'(d)];
        sidx = win; offs = o;
        split = fwd && (win == 0 || win == 2) && o == 0 && size == 4;
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R13 ready before accept"}, 32'(req_ready), 1);
    req_valid = 1'b1; req_write = w; req_addr = AW'(addr);
    req_size = 3'(size); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (upd) msel[ch] = d;
    chk(drv_valid == fwd, {tag, " drv_valid"}, 32'(drv_valid), 32'(fwd));
    chk(req_ready == 1'b0 && rsp_valid == 1'b0, {tag, " R13 busy beat"}, {req_ready, rsp_valid}, 0);
    lo = {beat_cnt[9:0], 6'(1 << sidx)};
    if (fwd) begin
      chk(drv_strobe == 6'(1 << sidx), {tag, " strobe"}, 32'(drv_strobe), 32'(1 << sidx));
      chk(drv_offset == 4'(offs), {tag, " offset"}, 32'(drv_offset), 32'(offs));
      chk(drv_write == w, {tag, " write"}, 32'(drv_write), 32'(w));
      chk(drv_size == 3'(split ? 2 : size), {tag, " size"}, 32'(drv_size), 32'(split ? 2 : size));
      if (win != 4) chk(drv_dev == d, {tag, " R9 dev"}, 32'(drv_dev), 32'(d));
      if (w) chk(drv_wdata == (split ? {16'h0, wd[15:0]} : wd), {tag, " wdata"}, drv_wdata,
                 split ? {16'h0, wd[15:0]} : wd);
    end
    exp_rd = (fwd && !w) ? {12'hD00, 4'(offs), lo} : 32'h0;
    if (split) begin
      @(negedge clk);
      hi = {beat_cnt[9:0], 6'(1 << sidx)};
      chk(drv_valid && drv_offset == 4'h0 && drv_size == 3'd2, {tag, " R11 second beat"},
          {drv_valid, drv_offset, drv_size}, {1'b1, 4'h0, 3'd2});
      if (w) chk(drv_wdata == {16'h0, wd[31:16]}, {tag, " R11 high half"}, drv_wdata, {16'h0, wd[31:16]});
      chk(rsp_valid == 1'b0, {tag, " R13 no early rsp"}, 32'(rsp_valid), 0);
      exp_rd = w ? 32'h0 : {hi, lo};
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, {tag, " R13 rsp_valid"}, 32'(rsp_valid), 1);
    chk(rsp_err == err, {tag, " rsp_err"}, 32'(rsp_err), 32'(err));
    chk(rsp_rdata == exp_rd, {tag, " rsp_rdata"}, rsp_rdata, exp_rd);
    chk(drv_valid == 1'b0 && req_ready == 1'b1, {tag, " R13 rsp cycle"}, {drv_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) mb[i] = 0;
    msel[0] = 0; msel[1] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(req_ready == 1 && rsp_valid == 0 && drv_valid == 0, "R1 reset state",
        {req_ready, rsp_valid, drv_valid}, 3'b100);
    // R4: I/O disabled, legal write to select offset has no effect
    access(1, 6, 1, 32'h10, "R4 io off");
    // R3 both with I/O off and on
    access(0, 2, 3, 0, "R3 size3 io off");
    io_en = 1'b1; bm_en = 1'b1;
    // R1 select still drive 0 (fitted), R5 with all bases zero: priority window 0
    access(0, 2, 1, 0, "R1 R5 base zero pri");
    set_base(0, 16'h1F0); set_base(1, 16'h3F4); set_base(2, 16'h170);
    set_base(3, 16'h374); set_base(4, 16'hC000);
    // R2 zero load ignored
    set_base(0, 0);
    access(0, 16'h1F3, 1, 0, "R2 keep base");
    access(1, 16'h3F6, 1, 32'h5A, "R5 ctl write");
    access(0, 16'h176, 1, 0, "R5 sec cmd");
    // R6 miss
    access(0, 16'h0800, 1, 0, "R6 miss");
    access(0, 16'h3F8, 1, 0, "R6 above ctl");
    access(0, 16'h3F3, 1, 0, "R6 below ctl");
    access(0, 4, 3'd5, 0, "R3 size5");
    // R12
    access(0, 16'h1F1, 2, 0, "R12 word on reg");
    access(1, 16'h1F6, 2, 32'h10, "R12 word on select");
    access(0, 16'h1F0, 1, 0, "R12 byte on data");
    // R11
    access(0, 16'h1F0, 2, 0, "R11 word data");
    access(0, 16'h1F0, 4, 0, "R11 split read");
    access(1, 16'h1F0, 4, 32'hBEEF_1234, "R11 split write");
    // R9/R10: drive 1 of channel 0 absent
    access(1, 16'h1F6, 1, 32'h10, "R9 R10 select absent");
    access(0, 16'h1F2, 1, 0, "R10 read absent");
    access(1, 16'h3F6, 1, 32'h1, "R10 write absent");
    access(0, 16'h1F0, 4, 0, "R10 no split absent");
    access(1, 16'h1F6, 1, 32'hE0, "R9 back to drive 0");
    access(0, 16'h1F2, 1, 0, "R9 drive0 read");
    // R9 channel 1 independent
    access(1, 16'h176, 1, 32'h10, "R9 sec select");
    access(0, 16'h172, 1, 0, "R9 sec absent");
    access(0, 16'h1F2, 1, 0, "R9 pri unaffected");
    drv_present = 4'b1101;
    access(0, 16'h172, 1, 0, "R10 sec fitted");
    // R7
    access(0, 16'hC002, 1, 0, "R7 dma lo");
    access(0, 16'hC00A, 2, 0, "R7 dma hi");
    access(1, 16'hC00C, 4, 32'h1234_5678, "R7 dma hi write");
    // R8
    bm_en = 1'b0;
    access(1, 16'hC004, 4, 32'hAAAA_5555, "R8 dma write dropped");
    access(0, 16'hC004, 4, 0, "R8 dma read kept");
    bm_en = 1'b1;
    // R5 overlap: control of channel 1 placed inside window 0
    set_base(3, 16'h1F4);
    access(0, 16'h1F5, 1, 0, "R5 overlap priority");
    access(0, 16'h1F9, 1, 0, "R5 overlap tail");
    // R4 again, I/O off with a miss is no error
    io_en = 1'b0;
    access(0, 16'h0800, 1, 0, "R4 miss io off");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule